// File: doc/BRIEF.md
# Three-Cycle Accumulator Processor

This block is a compact 16-bit processor built around a single accumulator. It fetches and executes an eight-operation instruction set from one shared, word-addressed memory. Its visible registers are a program counter, an instruction register and the accumulator. An operand register sits between the memory read port and the datapath. Every memory word that feeds the accumulator passes through this register. Because of it, every instruction takes exactly three clock cycles: a fetch, an operand cycle and an execute cycle.

The memory bus is plain and has no handshake. The processor drives an address together with a read or a write strobe. The attached memory must return read data combinationally in the same cycle, and it captures a write on the clock edge that ends the strobe. There is no back-pressure: the memory can never stall the processor, so the three-cycle rhythm is fixed. A stop instruction parks the processor until the next reset and raises a status pin.

Top module: `acc3_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, accumulator, instruction register and operand register are cleared to zero and `halted` goes low. After reset the first fetch reads address 0.
- R2: Each instruction occupies exactly three cycles. In the fetch cycle `mem_addr` equals the program counter and `mem_rd` is high. In the operand cycle and the execute cycle `mem_addr` equals the instruction's operand field. The program counter has already advanced by one when the operand cycle begins.
- R3: An instruction word carries the function code in bits 15:12 and the operand address S in bits 11:0. Code 0 (load) reads [S] in the operand cycle and copies it into the accumulator in the execute cycle.
- R4: Code 2 adds [S] to the accumulator and code 3 subtracts [S] from it. Both results wrap modulo 2^16.
- R5: Code 1 (store) raises `mem_wr` for the operand cycle only, with `mem_addr` = S and `mem_wdata` = accumulator. `mem_rd` stays low in that cycle.
- R6: Code 4 loads S into the program counter, so the next fetch reads address S.
- R7: Code 5 jumps to S when accumulator bit 15 is clear. Code 6 jumps to S when the accumulator is not zero. When its condition fails, execution continues at the next address.
- R8: Code 7 and the unused codes 8 to 15 stop the processor at the end of their execute cycle. `halted` then stays high, both strobes stay low and `mem_addr` holds still until reset.
- R9: `mem_rd` is high in every fetch cycle and, in operand cycles, only for codes 0, 2 and 3. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address to memory |
| mem_rd | output | 1 | Read strobe; memory answers on `mem_rdata` in the same cycle |
| mem_wr | output | 1 | Write strobe; memory stores `mem_wdata` at the rising edge |
| mem_wdata | output | 16 | Store data (accumulator value) |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High once a stop code has executed, until reset |

## Verification
The embedded assertions check the cycle-level rules on every cycle:
- the fetch, operand and execute phase order;
- the program counter stepping by one after each fetch;
- the accumulator taking the operand register on a load and the wrapped sum on an add;
- jump targets landing in the program counter;
- a single-cycle write strobe that never overlaps a read;
- the frozen bus once halted.

Whether conditional branches are decided from the right accumulator bits can only be seen in the bench's programs. The same holds for the number of cycles a whole program takes and for skipped stores leaving memory untouched. The bench compares the bus against a behavioural model on every clock and inspects memory afterwards.

// File: rtl/acc3_pkg.sv
package acc3_pkg;

  localparam int OPW = 4;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_XFER  = 2'd1,
    PH_EXEC  = 2'd2,
    PH_HALT  = 2'd3
  } phase_t;

  typedef enum logic [OPW-1:0] {
    OP_LDA = 4'd0,
    OP_STO = 4'd1,
    OP_ADD = 4'd2,
    OP_SUB = 4'd3,
    OP_JMP = 4'd4,
    OP_JGE = 4'd5,
    OP_JNE = 4'd6,
    OP_STP = 4'd7
  } opcode_t;

  typedef enum logic [1:0] {
    ACC_KEEP = 2'd0,
    ACC_LOAD = 2'd1,
    ACC_ADD  = 2'd2,
    ACC_SUB  = 2'd3
  } acc_op_t;

  typedef struct packed {
    logic    need_read;
    logic    do_write;
    acc_op_t acc_op;
    logic    take_jump;
    logic    stop;
  } ctrl_t;

endpackage

// File: rtl/acc3_sequencer.sv
module acc3_sequencer
  import acc3_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   stop,
  output phase_t phase
);

  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_FETCH: phase_d = PH_XFER;
      PH_XFER:  phase_d = PH_EXEC;
      PH_EXEC:  phase_d = stop ? PH_HALT : PH_FETCH;
      PH_HALT:  phase_d = PH_HALT;
      default:  phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_FETCH;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R2: fixed three-step rhythm
  a_r2_xfer_follows_fetch: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_FETCH |=> phase_q == PH_XFER);
  a_r2_exec_follows_xfer: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_XFER |=> phase_q == PH_EXEC);
  // R8: parked until reset
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_HALT |=> phase_q == PH_HALT);

endmodule

// File: rtl/acc3_decoder.sv
module acc3_decoder
  import acc3_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  acc,
  output ctrl_t          ctrl
);

  logic acc_neg;
  logic acc_zero;

  assign acc_neg  = acc[DW-1];
  assign acc_zero = (acc == '0);

  always_comb begin
    ctrl = '{need_read: 1'b0, do_write: 1'b0, acc_op: ACC_KEEP,
             take_jump: 1'b0, stop: 1'b0};
    case (op)
      OP_LDA: begin ctrl.need_read = 1'b1; ctrl.acc_op = ACC_LOAD; end
      OP_STO: ctrl.do_write = 1'b1;
      OP_ADD: begin ctrl.need_read = 1'b1; ctrl.acc_op = ACC_ADD; end
      OP_SUB: begin ctrl.need_read = 1'b1; ctrl.acc_op = ACC_SUB; end
      OP_JMP: ctrl.take_jump = 1'b1;
      OP_JGE: ctrl.take_jump = !acc_neg;
      OP_JNE: ctrl.take_jump = !acc_zero;
      default: ctrl.stop = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc3_datapath.sv
module acc3_datapath
  import acc3_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  phase_t         phase,
  input  ctrl_t          ctrl,
  input  logic [DW-1:0]  rdata,
  output logic [AW-1:0]  addr,
  output logic [DW-1:0]  wdata,
  output logic [OPW-1:0] op,
  output logic [DW-1:0]  acc
);

  localparam int OP_LSB = DW - OPW;

  logic [AW-1:0] pc_q;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] din_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] alu_y;
  logic [AW-1:0] operand;

  assign operand = ir_q[AW-1:0];
  assign op      = ir_q[DW-1:OP_LSB];

  always_comb begin
    case (ctrl.acc_op)
      ACC_LOAD: alu_y = din_q;
      ACC_ADD:  alu_y = acc_q + din_q;
      ACC_SUB:  alu_y = acc_q - din_q;
      default:  alu_y = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      din_q <= '0;
      acc_q <= '0;
    end else begin
      case (phase)
        PH_FETCH: begin
          ir_q <= rdata;
          pc_q <= pc_q + AW'(1);
        end
        PH_XFER: begin
          if (ctrl.need_read) din_q <= rdata;
        end
        PH_EXEC: begin
          acc_q <= alu_y;
          if (ctrl.take_jump) pc_q <= operand;
        end
        default: ;
      endcase
    end
  end

  assign addr  = (phase == PH_XFER || phase == PH_EXEC) ? operand : pc_q;
  assign wdata = acc_q;
  assign acc   = acc_q;

  // R1: reset clears every register
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && acc_q == '0 && ir_q == '0 && din_q == '0));
  // R2: PC has advanced once the fetch is over
  a_r2_pc_steps: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FETCH |=> pc_q == AW'($past(pc_q) + AW'(1)));
  // R3: load takes the operand register
  a_r3_load_from_din: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && ctrl.acc_op == ACC_LOAD) |=> acc_q == $past(din_q));
  // R4: add wraps modulo 2^DW
  a_r4_add_wraps: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && ctrl.acc_op == ACC_ADD) |=>
      acc_q == DW'($past(acc_q) + $past(din_q)));
  // R6: jump lands on the operand field
  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && ctrl.take_jump) |=> pc_q == $past(operand));

endmodule

// File: rtl/acc3_cpu.sv
module acc3_cpu
  import acc3_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);

  phase_t         phase;
  ctrl_t          ctrl;
  logic [OPW-1:0] op;
  logic [DW-1:0]  acc;

  acc3_sequencer u_seq (
    .clk   (clk),
    .rst   (rst),
    .stop  (ctrl.stop),
    .phase (phase)
  );

  acc3_decoder #(.DW(DW)) u_dec (
    .op   (op),
    .acc  (acc),
    .ctrl (ctrl)
  );

  acc3_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .ctrl  (ctrl),
    .rdata (mem_rdata),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .op    (op),
    .acc   (acc)
  );

  assign mem_rd = (phase == PH_FETCH) || (phase == PH_XFER && ctrl.need_read);
  assign mem_wr = (phase == PH_XFER) && ctrl.do_write;
  assign halted = (phase == PH_HALT);

  // R9: strobes never overlap
  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  // R5: write strobe lasts one cycle
  a_r5_write_single: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);
  // R8: bus frozen while halted
  a_r8_bus_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(mem_addr) && !mem_rd && !mem_wr));

endmodule

// File: tb/acc3_cpu_bench.sv
module acc3_cpu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [4096];

  int n_chk  = 0;
  int n_fail = 0;
  bit model_ok = 1'b0;

  // behavioural model state
  logic [11:0] m_pc;
  logic [15:0] m_acc, m_ir, m_din;
  int          m_step;

  always #5 clk = ~clk;

  acc3_cpu u_acc3_cpu (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit reads_op(input logic [3:0] op);
    return (op == 4'd0 || op == 4'd2 || op == 4'd3);
  endfunction

  // compare with model every cycle, then advance the model
  always @(negedge clk) begin
    if (!rst && model_ok) begin
      logic [3:0] op;
      op = m_ir[15:12];
      chk("R2 mem_addr", {20'd0, mem_addr},
          (m_step == 1 || m_step == 2) ? {20'd0, m_ir[11:0]} : {20'd0, m_pc});
      chk("R9 mem_rd", {31'd0, mem_rd},
          {31'd0, (m_step == 0) || (m_step == 1 && reads_op(op))});
      chk("R5 mem_wr", {31'd0, mem_wr}, {31'd0, (m_step == 1 && op == 4'd1)});
      if (m_step == 1 && op == 4'd1) chk("R5 mem_wdata", {16'd0, mem_wdata}, {16'd0, m_acc});
      chk("R8 halted", {31'd0, halted}, {31'd0, m_step == 3});
    end
    if (rst) begin
      m_pc = '0; m_acc = '0; m_ir = '0; m_din = '0; m_step = 0; model_ok = 1'b1;
    end else if (model_ok) begin
      case (m_step)
        0: begin m_ir = mem[m_pc]; m_pc = m_pc + 12'd1; m_step = 1; end
        1: begin
          if (reads_op(m_ir[15:12])) m_din = mem[m_ir[11:0]];
          m_step = 2;
        end
        2: begin
          m_step = 0;
          case (m_ir[15:12])
            4'd0: m_acc = m_din;
            4'd1: ;
            4'd2: m_acc = m_acc + m_din;
            4'd3: m_acc = m_acc - m_din;
            4'd4: m_pc = m_ir[11:0];
            4'd5: if (!m_acc[15]) m_pc = m_ir[11:0];
            4'd6: if (m_acc != 16'd0) m_pc = m_ir[11:0];
            default: m_step = 3;
          endcase
        end
        default: ;
      endcase
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'hDEAD;
  endtask

  task automatic run_to_halt(output int cycles);
    cycles = 0;
    @(negedge clk);
    while (!halted && cycles < 2000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    // program 1
    clear_mem();
    mem[12'h100] = 16'h7FFF; mem[12'h101] = 16'h0001;
    mem[12'h102] = 16'h8000; mem[12'h103] = 16'h1234;
    mem[12'h000] = 16'h0100; mem[12'h001] = 16'h2101; mem[12'h002] = 16'h1200;
    mem[12'h003] = 16'h5020; mem[12'h004] = 16'h3102; mem[12'h005] = 16'h6020;
    mem[12'h006] = 16'h3101; mem[12'h007] = 16'h1205; mem[12'h008] = 16'h600A;
    mem[12'h009] = 16'h1201; mem[12'h00A] = 16'h2101; mem[12'h00B] = 16'h500D;
    mem[12'h00C] = 16'h1202; mem[12'h00D] = 16'h0103; mem[12'h00E] = 16'h4010;
    mem[12'h00F] = 16'h1203; mem[12'h010] = 16'h1204; mem[12'h011] = 16'h7000;
    mem[12'h020] = 16'h7000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset addr", {20'd0, mem_addr}, 32'h0);
    chk("R1 reset rd", {31'd0, mem_rd}, 32'h1);
    chk("R1 reset halted", {31'd0, halted}, 32'h0);
    @(posedge clk); #1 rst = 1'b0;
    run_to_halt(cyc);
    chk("R2 program cycles", cyc, 45);
    chk("R4 add wrap", {16'd0, mem[12'h200]}, 32'h8000);
    chk("R4 sub wrap", {16'd0, mem[12'h205]}, 32'hFFFF);
    chk("R7 jne taken skips", {16'd0, mem[12'h201]}, 32'hDEAD);
    chk("R7 jge zero taken skips", {16'd0, mem[12'h202]}, 32'hDEAD);
    chk("R6 jmp skips", {16'd0, mem[12'h203]}, 32'hDEAD);
    chk("R3 load then store", {16'd0, mem[12'h204]}, 32'h1234);
    repeat (8) @(negedge clk);
    chk("R8 addr frozen", {20'd0, mem_addr}, 32'h012);
    chk("R8 rd low", {31'd0, mem_rd}, 32'h0);
    chk("R8 still halted", {31'd0, halted}, 32'h1);

    // program 2: reset clears ACC, unused code stops
    @(posedge clk); #1 rst = 1'b1;
    clear_mem();
    mem[12'h000] = 16'h1300; mem[12'h001] = 16'hA000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 halted cleared", {31'd0, halted}, 32'h0);
    @(posedge clk); #1 rst = 1'b0;
    run_to_halt(cyc);
    chk("R8 unused code stops", cyc, 6);
    chk("R1 acc cleared", {16'd0, mem[12'h300]}, 32'h0);
    repeat (4) @(negedge clk);
    chk("R8 addr held", {20'd0, mem_addr}, 32'h002);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule